// File: doc/BRIEF.md
# Packed-Byte Block Transmitter

This engine streams a counted run of bytes to a serial transmitter. The bytes sit two to a 16-bit memory word, and the upper half of each word goes out first. A control block in memory drives the engine. Relative to the control block's base address, word 4 combines a byte-select flag in bit 15 with a 15-bit remaining count. Word 5 points at the memory word that holds the next byte. Word 6 holds a command to issue once the run is finished. Word 2 is a status word that the engine clears when it starts.

A wakeup pulse starts the engine from idle when the control-block base input is nonzero. For each byte, the engine reads word 4 and word 5, then fetches the data word and extracts the selected half. It offers the byte to the transmitter and holds it until the transmitter is ready. Only after that does it write back the updated word 4 and word 5. When the count field reaches zero, it copies word 6 to a device control register at a fixed address, pulses `done_o` with post code 0, and returns to idle.

Memory is a single synchronous port with one cycle of read latency. The control-register write goes through the same port.

Top module: `pbx_block_sender`

## Requirements
- R1: After reset the engine is idle, with `tx_valid_o`, `done_o` and `mem_req_o` all low.
- R2: A wakeup in idle while `cb_base_i` is zero is ignored: no memory write, no byte sent, no done pulse.
- R3: A wakeup in idle with a nonzero `cb_base_i` writes 0 to word 2 on the next cycle and then goes on to the first byte with no further wakeup.
- R4: When bit 15 of word 4 is 0, the byte sent is bits 15:8 of the addressed data word, presented on `tx_byte_o[7:0]`.
- R5: When bit 15 of word 4 is 1, the byte sent is bits 7:0 of the addressed data word.
- R6: After each accepted byte, word 4 is rewritten as its old value plus 0x7FFF (modulo 2^16). This decrements the count in bits 14:0 and inverts bit 15. After a run of N bytes started with select S, word 4 reads {S xor (N mod 2), 15'b0}.
- R7: After a byte taken from bits 15:8, word 5 is rewritten unchanged. After a byte taken from bits 7:0, word 5 is rewritten plus one.
- R8: When the count field of word 4 is zero, the value of word 6 is written once to address `CTRL_ADDR` (default 0xFFC0). In the next cycle `done_o` is high.
- R9: Completion is a `done_o` pulse exactly one cycle wide, with `post_code_o` equal to 0, followed by a return to idle.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` holds its value. A byte is transferred only in a cycle where both are high.
- R11: A block whose count field is zero sends no byte. It still writes the command and posts completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Wakeup pulse, acted on only in idle |
| cb_base_i | input | AW | Control block base address, 0 means none |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |
| tx_valid_o | output | 1 | Byte offered to the transmitter |
| tx_byte_o | output | DW/2 | Byte value |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| done_o | output | 1 | One-cycle completion pulse |
| post_code_o | output | 2 | Completion code, 0 on normal end |

## Verification
The assertions check the following on every cycle:
- the transmit hold rule;
- the single-cycle done pulse and its zero code;
- the control-register write being followed by done;
- the status clear at start;
- the rejection of a wakeup without a control block.

Only the bench's sweeps can show that the right half of the right word was sent in the right order and that the final word 4 and word 5 hold the values that follow from the start count, select bit and address. The sweeps cover every count from 0 to 12, both starting halves, and three transmitter ready patterns.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_RD4, ST_RD5, ST_DEC, ST_FETCH, ST_BYTE,
    ST_SEND, ST_WB4, ST_WB5, ST_RDCMD, ST_CMD, ST_DONE
  } pbx_state_e;

  localparam int unsigned STAT_OFS = 2;
  localparam int unsigned CNT_OFS  = 4;
  localparam int unsigned ADR_OFS  = 5;
  localparam int unsigned CMD_OFS  = 6;
  localparam logic [1:0]  POST_OK  = 2'd0;
endpackage

// File: rtl/pbx_seq.sv
module pbx_seq
  import pbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wake,
  input  logic       cb_present,
  input  logic       count_zero,
  input  logic       tx_ready,
  output pbx_state_e state
);
  pbx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (wake && cb_present) state_d = ST_CLR;
      ST_CLR:   state_d = ST_RD4;
      ST_RD4:   state_d = ST_RD5;
      ST_RD5:   state_d = ST_DEC;
      ST_DEC:   state_d = count_zero ? ST_RDCMD : ST_FETCH;
      ST_FETCH: state_d = ST_BYTE;
      ST_BYTE:  state_d = ST_SEND;
      ST_SEND:  if (tx_ready) state_d = ST_WB4;
      ST_WB4:   state_d = ST_WB5;
      ST_WB5:   state_d = ST_RD4;
      ST_RDCMD: state_d = ST_CMD;
      ST_CMD:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pbx_datapath.sv
module pbx_datapath
  import pbx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  pbx_state_e    state,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] cnt_next,
  output logic [AW-1:0] addr_next,
  output logic [DW/2-1:0] byte_q,
  output logic          count_zero
);
  localparam int unsigned BW    = DW / 2;
  localparam int unsigned CNT_W = DW - 1;
  localparam logic [DW-1:0] STEP = {1'b0, {CNT_W{1'b1}}};

  logic [DW-1:0] cnt_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      addr_q <= '0;
      byte_q <= '0;
    end else begin
      case (state)
        ST_RD5:  cnt_q  <= rdata;
        ST_DEC:  addr_q <= rdata[AW-1:0];
        ST_BYTE: byte_q <= cnt_q[DW-1] ? rdata[BW-1:0] : rdata[DW-1:BW];
        default: ;
      endcase
    end
  end

  assign cnt_next   = cnt_q + STEP;
  assign addr_next  = cnt_q[DW-1] ? addr_q + AW'(1) : addr_q;
  assign count_zero = (cnt_q[CNT_W-1:0] == '0);
endmodule

// File: rtl/pbx_memport.sv
module pbx_memport
  import pbx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFFC0
) (
  input  pbx_state_e    state,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] word_addr,
  input  logic [DW-1:0] cnt_next,
  input  logic [AW-1:0] addr_next,
  input  logic [DW-1:0] rdata,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  always_comb begin
    req   = 1'b1;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (state)
      ST_CLR:   begin we = 1'b1; addr = base + AW'(STAT_OFS); end
      ST_RD4:   addr = base + AW'(CNT_OFS);
      ST_RD5:   addr = base + AW'(ADR_OFS);
      ST_FETCH: addr = word_addr;
      ST_WB4:   begin we = 1'b1; addr = base + AW'(CNT_OFS); wdata = cnt_next; end
      ST_WB5:   begin we = 1'b1; addr = base + AW'(ADR_OFS); wdata = DW'(addr_next); end
      ST_RDCMD: addr = base + AW'(CMD_OFS);
      ST_CMD:   begin we = 1'b1; addr = CTRL_ADDR; wdata = rdata; end
      default:  req = 1'b0;
    endcase
  end
endmodule

// File: rtl/pbx_block_sender.sv
module pbx_block_sender
  import pbx_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFFC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wake_i,
  input  logic [AW-1:0] cb_base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          tx_valid_o,
  output logic [DW/2-1:0] tx_byte_o,
  input  logic          tx_ready_i,
  output logic          done_o,
  output logic [1:0]    post_code_o
);
  pbx_state_e      state;
  logic [DW-1:0]   cnt_next;
  logic [AW-1:0]   addr_next;
  logic [AW-1:0]   word_addr;
  logic            count_zero;
  logic            busy;

  pbx_seq u_seq (
    .clk(clk), .rst(rst), .wake(wake_i),
    .cb_present(cb_base_i != '0), .count_zero(count_zero),
    .tx_ready(tx_ready_i), .state(state)
  );

  pbx_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .state(state), .rdata(mem_rdata_i),
    .cnt_next(cnt_next), .addr_next(addr_next), .byte_q(tx_byte_o),
    .count_zero(count_zero)
  );

  // The data word address is the unincremented pointer held for the byte.
  assign word_addr = u_dp.addr_q;

  pbx_memport #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_mp (
    .state(state), .base(cb_base_i), .word_addr(word_addr),
    .cnt_next(cnt_next), .addr_next(addr_next), .rdata(mem_rdata_i),
    .req(mem_req_o), .we(mem_we_o), .addr(mem_addr_o), .wdata(mem_wdata_o)
  );

  assign busy        = (state != ST_IDLE);
  assign tx_valid_o  = (state == ST_SEND);
  assign done_o      = (state == ST_DONE);
  assign post_code_o = POST_OK;
endmodule

// File: rtl/pbx_block_sender_chk.sv
module pbx_block_sender_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFFC0
) (
  input logic          clk,
  input logic          rst,
  input logic          wake_i,
  input logic [AW-1:0] cb_base_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          tx_valid_o,
  input logic [DW/2-1:0] tx_byte_o,
  input logic          tx_ready_i,
  input logic          done_o,
  input logic [1:0]    post_code_o,
  input logic          busy
);
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_code_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (post_code_o == 2'd0));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy);

  p_ctrl_then_done_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o && mem_addr_o == CTRL_ADDR) |=> done_o);

  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && wake_i && cb_base_i == '0) |=> (!busy && !mem_req_o));

  p_clear_status_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && wake_i && cb_base_i != '0) |=>
      (mem_req_o && mem_we_o && mem_wdata_o == '0 &&
       mem_addr_o == $past(cb_base_i) + AW'(2)));

  p_we_with_req: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);
endmodule

bind pbx_block_sender pbx_block_sender_chk #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wake_i(wake_i), .cb_base_i(cb_base_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
  .tx_ready_i(tx_ready_i), .done_o(done_o), .post_code_o(post_code_o),
  .busy(busy)
);

// File: tb/test_pbx_block_sender.sv
module test_pbx_block_sender;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam logic [15:0] CTRL = 16'hFFC0;
  localparam logic [15:0] BASE = 16'h0010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake = 1'b0;
  logic [15:0] cb_base = BASE;
  logic mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic tx_valid, tx_ready, done;
  logic [7:0] tx_byte;
  logic [1:0] post_code;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  int ready_mode = 0;
  int cyc = 0;

  logic [15:0] mem [0:255];
  logic [7:0]  tx_log [0:1023];
  int tx_n = 0, done_n = 0, ctrl_n = 0, wr_n = 0;
  logic [15:0] ctrl_val = '0;
  bit hold_pend = 0;
  logic [7:0] hold_byte = '0;
  bit prev_done = 0;

  always #2 clk = ~clk;

  pbx_block_sender #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL)) i_pbx_block_sender (
    .clk(clk), .rst(rst), .wake_i(wake), .cb_base_i(cb_base),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .tx_ready_i(tx_ready),
    .done_o(done), .post_code_o(post_code)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        if (mem_addr == CTRL) ctrl_val <= mem_wdata;
        else mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      1: tx_ready = cyc[0];
      2: tx_ready = (cyc % 3) == 0;
      default: tx_ready = 1'b1;
    endcase
  end

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (hold_pend) begin
        chk(tx_valid && tx_byte == hold_byte, "R10 hold", {23'd0, tx_valid, tx_byte}, {24'd1, hold_byte});
      end
      hold_pend = tx_valid && !tx_ready;
      hold_byte = tx_byte;
      if (tx_valid && tx_ready) begin
        tx_log[tx_n % 1024] = tx_byte;
        tx_n++;
      end
      if (mem_req && mem_we) begin
        wr_n++;
        if (mem_addr == CTRL) ctrl_n++;
      end
      if (done) begin
        done_n++;
        chk(post_code == 2'd0 && !prev_done, "R9 pulse", {30'd0, post_code}, 32'd0);
      end
      prev_done = done;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_block(input bit sel0, input int cnt, input logic [15:0] a0, input logic [15:0] cmd);
    int t0, d0, c0, waitc;
    bit s;
    logic [15:0] a;
    logic [7:0] exp;
    for (int i = 8'h40; i < 256; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i) + 8'h13};
    mem[BASE[7:0] + 2] = 16'hBEEF;
    mem[BASE[7:0] + 4] = {sel0, 15'(cnt)};
    mem[BASE[7:0] + 5] = a0;
    mem[BASE[7:0] + 6] = cmd;
    @(negedge clk);
    t0 = tx_n; d0 = done_n; c0 = ctrl_n;
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    waitc = 0;
    while (done_n == d0 && waitc < 3000) begin @(negedge clk); waitc++; end
    cycles(2);
    s = sel0; a = a0;
    for (int k = 0; k < cnt; k++) begin
      exp = s ? mem[a[7:0]][7:0] : mem[a[7:0]][15:8];
      if (s) chk(tx_log[(t0 + k) % 1024] == exp, "R5 right byte", {24'd0, tx_log[(t0 + k) % 1024]}, {24'd0, exp});
      else   chk(tx_log[(t0 + k) % 1024] == exp, "R4 left byte", {24'd0, tx_log[(t0 + k) % 1024]}, {24'd0, exp});
      if (s) a = a + 16'd1;
      s = ~s;
    end
    chk(tx_n - t0 == cnt, (cnt == 0) ? "R11 zero count" : "R4 byte count", tx_n - t0, cnt);
    chk(mem[BASE[7:0] + 4] == {s, 15'd0}, "R6 word4", {16'd0, mem[BASE[7:0] + 4]}, {16'd0, s, 15'd0});
    chk(mem[BASE[7:0] + 5] == a, "R7 word5", {16'd0, mem[BASE[7:0] + 5]}, {16'd0, a});
    chk(mem[BASE[7:0] + 2] == 16'd0, "R3 status clear", {16'd0, mem[BASE[7:0] + 2]}, 32'd0);
    chk(ctrl_n - c0 == 1 && ctrl_val == cmd, "R8 control write", {16'd0, ctrl_val}, {16'd0, cmd});
    chk(done_n - d0 == 1, "R9 done count", done_n - d0, 1);
  endtask

  initial begin
    tx_ready = 1'b1;
    cycles(3);
    chk(!tx_valid && !done && !mem_req, "R1 reset", {29'd0, tx_valid, done, mem_req}, 32'd0);
    rst = 1'b0;
    cycles(2);
    chk(!tx_valid && !done && !mem_req, "R1 idle", {29'd0, tx_valid, done, mem_req}, 32'd0);

    begin : no_cb
      int t0, d0, w0;
      cb_base = '0;
      t0 = tx_n; d0 = done_n; w0 = wr_n;
      wake = 1'b1; @(negedge clk); wake = 1'b0;
      cycles(20);
      chk(tx_n == t0 && done_n == d0 && wr_n == w0, "R2 ignore", wr_n - w0, 0);
      cb_base = BASE;
    end

    for (int m = 0; m < 3; m++) begin
      ready_mode = m;
      for (int c = 0; c <= 12; c++)
        for (int sl = 0; sl < 2; sl++)
          run_block(sl[0], c, 16'h0040 + 16'(c * 3), 16'h1200 + 16'(c * 16 + sl * 2 + m));
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule